// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on separate clocks. Words of a parameterised width (nine bits by default) are written under two write enables and read under two read enables. Four active-low status outputs are produced: empty and almost-empty in the read clock domain, and full and almost-full in the write clock domain. The almost-empty and almost-full levels are set to single-word precision from two threshold inputs, which come from an offset register bank outside this block.

The second write-enable pin has two uses. Its level is captured while reset is held. If it is captured high, the pin is a second active-high write enable and both thresholds are fixed at 7. If it is captured low, the block is in load mode. In load mode the pin becomes an active-low load control: while it is low, FIFO writes stop and a load strobe tells the external offset bank to take the data input. Pointers cross between the clock domains as Gray code through two-flop synchronisers. A flag may therefore release late, but it never releases early.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: The level of `wen2_ld` on the last write-clock edge with `rst_n` low selects the mode: 1 gives two-enable mode and 0 gives load mode. The mode then holds until the next reset.
- R2: On a write-clock rising edge, one word from `din` is stored only when `wen1_n`=0, `wen2_ld`=1 and `ff_n`=1.
- R3: In load mode, `cfg_load` is high exactly when `rst_n`=1, `wen1_n`=0 and `wen2_ld`=0. No FIFO word is stored in that case.
- R4: On a read-clock rising edge, the oldest word is moved into the output register only when `ren1_n`=0, `ren2_n`=0 and `ef_n`=1.
- R5: `ff_n` is low when the write side sees DEPTH unread words. While it is low, no write is stored.
- R6: While `ef_n` is low, read attempts change neither the output register nor the read position.
- R7: Both flags update on the third edge of the opposite clock after the change that causes them. `ef_n` goes high on the third read-clock edge after the first write lands. `ff_n` goes high on the third write-clock edge after a read frees a slot.
- R8: `pae_n` is low while the read side sees n or fewer unread words, and high at n+1 or more.
- R9: `paf_n` is low while the write side sees at least DEPTH−m unread words, and high otherwise.
- R10: In two-enable mode, n and m are both 7 and `ae_lvl`/`af_lvl` are ignored. In load mode, n=`ae_lvl` and m=`af_lvl`.
- R11: During reset, `ef_n`=0, `pae_n`=0, `ff_n`=1, `paf_n`=1 and the output register is 0. No read or write takes place.
- R12: `q` shows the output register when `oe_n`=0 and is 0 when `oe_n`=1.
- R13: Words come out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, synchronous to each clock. Hold it for at least three edges of each clock. |
| wclk | input | 1 | Write clock |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable, or load control; the mode is captured during reset |
| din | input | DATA_W | Write data |
| ae_lvl | input | AW | Almost-empty threshold n, used in load mode |
| af_lvl | input | AW | Almost-full threshold m, used in load mode |
| cfg_load | output | 1 | Strobe telling the external offset bank to capture `din` |
| ff_n | output | 1 | Full flag, active low, write domain |
| paf_n | output | 1 | Almost-full flag, active low, write domain |
| rclk | input | 1 | Read clock |
| ren1_n | input | 1 | Active-low read enable |
| ren2_n | input | 1 | Active-low read enable |
| oe_n | input | 1 | Active-low output qualifier |
| q | output | DATA_W | Read data |
| ef_n | output | 1 | Empty flag, active low, read domain |
| pae_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The bench first fills the buffer to full and then keeps writing. A design that ignores the full flag would overwrite unread words, and a later read would return the wrong data. It also keeps reading after the buffer is empty. A design that lets such a read through would change `q` or fall behind its pointers. The bench exercises both modes with non-default thresholds, so a design that takes `ae_lvl`/`af_lvl` in two-enable mode, or keeps the defaults in load mode, moves `pae_n`/`paf_n` at the wrong fill level. The model tracks the three-edge flag latency exactly, so a missing or extra synchroniser stage shows up as a flag one cycle early or late. A long mixed random phase checks word ordering across pointer wraparound.

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo #(
  parameter int DATA_W  = 9,
  parameter int DEPTH   = 256,
  parameter int DEF_LVL = 7,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              rst_n,
  input  logic              wclk,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic [DATA_W-1:0] din,
  input  logic [AW-1:0]     ae_lvl,
  input  logic [AW-1:0]     af_lvl,
  output logic              cfg_load,
  output logic              ff_n,
  output logic              paf_n,
  input  logic              rclk,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q,
  output logic              ef_n,
  output logic              pae_n
);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic              two_en;
  logic [PW-1:0]     wbin, wgray, rq1, rq2;
  logic [PW-1:0]     rbin, rgray, wq1, wq2;
  logic [DATA_W-1:0] dout;

  // write domain
  logic          wr_go;
  logic [PW-1:0] wbin_nx, wcnt_nx;
  logic [AW-1:0] m_eff;

  assign wr_go    = rst_n & ~wen1_n & wen2_ld & ff_n;
  assign wbin_nx  = wbin + PW'(wr_go);
  assign wcnt_nx  = wbin_nx - g2b(rq2);
  assign m_eff    = two_en ? AW'(DEF_LVL) : af_lvl;
  assign cfg_load = rst_n & ~two_en & ~wen2_ld & ~wen1_n;

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      two_en <= wen2_ld;
      wbin   <= '0;
      wgray  <= '0;
      rq1    <= '0;
      rq2    <= '0;
      ff_n   <= 1'b1;
      paf_n  <= 1'b1;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      rq1    <= rgray;
      rq2    <= rq1;
      ff_n   <= (wcnt_nx != PW'(DEPTH));
      paf_n  <= (int'(wcnt_nx) < DEPTH - int'(m_eff));
    end
  end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= din;

  // read domain
  logic          rd_go;
  logic [PW-1:0] rbin_nx, rcnt_nx;
  logic [AW-1:0] n_eff;

  assign rd_go   = rst_n & ~ren1_n & ~ren2_n & ef_n;
  assign rbin_nx = rbin + PW'(rd_go);
  assign rcnt_nx = g2b(wq2) - rbin_nx;
  assign n_eff   = two_en ? AW'(DEF_LVL) : ae_lvl;

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
      ef_n  <= 1'b0;
      pae_n <= 1'b0;
      dout  <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      wq1   <= wgray;
      wq2   <= wq1;
      ef_n  <= (rcnt_nx != '0);
      pae_n <= (int'(rcnt_nx) > int'(n_eff));
      if (rd_go) dout <= mem[rbin[AW-1:0]];
    end
  end

  assign q = oe_n ? '0 : dout;

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n) !ff_n |=> $stable(wbin)); // R5
  AST_LOAD_NO_WRITE: assert property (@(posedge wclk) disable iff (!rst_n) (!two_en && !wen2_ld) |=> $stable(wbin)); // R3
  AST_FULL_IN_AF: assert property (@(posedge wclk) disable iff (!rst_n) !ff_n |-> !paf_n); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n) !ef_n |=> $stable(rbin)); // R6
  AST_EMPTY_HOLDS_Q: assert property (@(posedge rclk) disable iff (!rst_n) !ef_n |=> $stable(dout)); // R6
  AST_EMPTY_IN_AE: assert property (@(posedge rclk) disable iff (!rst_n) !ef_n |-> !pae_n); // R8
  AST_OE_GATES_Q: assert property (@(posedge rclk) disable iff (!rst_n) oe_n |-> (q == '0)); // R12

endmodule

// File: tb/dual_clock_flag_fifo_test.sv
`timescale 1ns/1ps
module dual_clock_flag_fifo_test;
  localparam int D  = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
  logic [8:0] din;
  logic [AW-1:0] ae_lvl, af_lvl;
  logic cfg_load, ff_n, paf_n, ef_n, pae_n;
  logic [8:0] q;

  dual_clock_flag_fifo #(.DATA_W(9), .DEPTH(D), .DEF_LVL(7)) uut (
    .rst_n(rst_n), .wclk(clk), .wen1_n(wen1_n), .wen2_ld(wen2_ld), .din(din),
    .ae_lvl(ae_lvl), .af_lvl(af_lvl), .cfg_load(cfg_load), .ff_n(ff_n), .paf_n(paf_n),
    .rclk(clk), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .q(q),
    .ef_n(ef_n), .pae_n(pae_n));

  int tests = 0, fails = 0;
  string ph = "R11";

  int W, R;
  int wh[$], rh[$];
  logic [8:0] fq[$];
  logic m_two, e_ef, e_pae, e_ff, e_paf;
  logic [8:0] e_dout;

  task automatic chk(string sig, string req, logic [8:0] act, logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s: got %0h expected %0h at %0t", req, ph, sig, act, exp, $time);
    end
  endtask

  task automatic cycle();
    int c, wv, rv, n, m;
    logic dw, dr;
    c = wh.size();
    if (!rst_n) begin
      m_two = wen2_ld; W = 0; R = 0; fq.delete(); e_dout = '0;
      e_ef = 0; e_pae = 0; e_ff = 1; e_paf = 1;
    end else begin
      dw = !wen1_n && wen2_ld && e_ff;
      dr = !ren1_n && !ren2_n && e_ef;
      if (dr) e_dout = fq.pop_front();
      if (dw) fq.push_back(din);
      W += int'(dw); R += int'(dr);
      wv = (c >= 3) ? wh[c-3] : 0;
      rv = (c >= 3) ? rh[c-3] : 0;
      n = m_two ? 7 : int'(ae_lvl);
      m = m_two ? 7 : int'(af_lvl);
      e_ef  = (wv - R) != 0;
      e_pae = (wv - R) > n;
      e_ff  = (W - rv) != D;
      e_paf = (W - rv) < D - m;
    end
    wh.push_back(W); rh.push_back(R);
    @(posedge clk); @(negedge clk);
    chk("q",        "R13 R12", q, oe_n ? 9'h0 : e_dout);
    chk("ef_n",     "R7",  9'(ef_n),  9'(e_ef));
    chk("pae_n",    "R8",  9'(pae_n), 9'(e_pae));
    chk("ff_n",     "R5",  9'(ff_n),  9'(e_ff));
    chk("paf_n",    "R9",  9'(paf_n), 9'(e_paf));
    chk("cfg_load", "R3",  9'(cfg_load), 9'(rst_n && !m_two && !wen1_n && !wen2_ld));
  endtask

  task automatic idle();
    wen1_n = 1; wen2_ld = 1; ren1_n = 1; ren2_n = 1;
  endtask

  task automatic do_reset(logic mode);
    ph = "R11 R1";
    rst_n = 0; idle(); wen2_ld = mode;
    repeat (4) cycle();
    rst_n = 1; wen2_ld = 1;
  endtask

  initial begin
    rst_n = 0; oe_n = 0; din = '0; ae_lvl = 4'd2; af_lvl = 4'd3; idle();
    @(negedge clk);
    do_reset(1'b1);
    ph = "R10 R2";
    for (int i = 0; i < 12; i++) begin
      wen1_n = 0; wen2_ld = (i % 3 != 1); din = 9'(i * 37 + 5); cycle();
    end
    idle(); repeat (4) cycle();
    ph = "R4 R13";
    for (int i = 0; i < 14; i++) begin
      ren1_n = 0; ren2_n = (i % 4 == 2); cycle();
    end
    ph = "R6";
    ren1_n = 0; ren2_n = 0; repeat (6) cycle();
    idle(); repeat (3) cycle();
    ph = "R5";
    for (int i = 0; i < 24; i++) begin
      wen1_n = 0; din = 9'(300 + i); cycle();
    end
    idle(); repeat (4) cycle();
    ph = "R12";
    oe_n = 1; ren1_n = 0; ren2_n = 0; repeat (5) cycle();
    oe_n = 0; repeat (15) cycle();
    idle(); repeat (4) cycle();

    do_reset(1'b0);
    ph = "R3";
    wen1_n = 0; wen2_ld = 0; din = 9'h055; repeat (3) cycle();
    wen2_ld = 1; idle(); repeat (4) cycle();
    ph = "R8 R9 R10";
    for (int i = 0; i < 20; i++) begin
      wen1_n = 0; wen2_ld = 1; din = 9'(i + 100); cycle();
    end
    idle(); repeat (4) cycle();
    for (int i = 0; i < 20; i++) begin
      ren1_n = 0; ren2_n = 0; cycle();
    end
    idle(); repeat (4) cycle();

    ph = "R13 R7";
    ae_lvl = 4'd5; af_lvl = 4'd1;
    for (int i = 0; i < 800; i++) begin
      wen1_n  = ($urandom % 4) == 0;
      wen2_ld = ($urandom % 8) != 0;
      ren1_n  = ($urandom % 3) == 0;
      ren2_n  = ($urandom % 5) == 0;
      din     = 9'($urandom);
      cycle();
    end
    idle(); repeat (6) cycle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule